// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two independent 16-bit count registers, each kept as a low byte and a high byte. Every count register can advance on an internal machine-cycle tick or on falling transitions of its own count pin. It advances only while its run bit is set. When its gate bit is set, the matching gate pin must also be high. A small register port lets software set the operating mode, start and stop each timer, load or read the count bytes, and read or clear the overflow flags. The two flags also drive the `ovf_flag` output pins.

The machine-cycle tick comes from a free-running divider of the core clock. Its default ratio is twelve. Each timer works in one of four modes, picked by a two-bit field written by software:
- **Mode 0**: 13-bit count.
- **Mode 1**: full 16-bit count.
- **Mode 2**: 8-bit count that reloads itself from the high byte.
- **Mode 3**: split mode.

In split mode, timer 0 turns into two 8-bit counters. The second of these borrows timer 1's run bit and timer 1's overflow flag. Timer 1 placed in split mode stops.

The mode only changes when software writes the mode register, and the change takes effect from the next clock. Within a mode, the count passes between three conditions:
- **idle**: the timer is not enabled.
- **counting**: the timer is enabled and the count is not all ones.
- **wrap**: an enabled increment from the all-ones count. It returns the count to zero, or to the reload value in mode 2, and sets the flag.

Top module: `dual_tmr_ctr`

## Requirements
- R1: After reset, every register reads 0x00 and both `ovf_flag` outputs are 0.
- R2: The register map is as follows. Writes load the register on the clock edge where `wr_en` is high.
  - Address 0 is the mode register. Bits [3:0] configure timer 0 and bits [7:4] configure timer 1. Each 4-bit field is {gate, count-select, mode[1:0]}.
  - Address 1 is the control register, {4'b0, flag1, flag0, run1, run0}.
  - Addresses 2 and 3 are the low and high bytes of timer 0.
  - Addresses 4 and 5 are the low and high bytes of timer 1.
  - Addresses 6 and 7 read 0x00.
- R3: In timer operation (count-select 0), an enabled timer adds exactly one per machine cycle. A machine cycle is `CYC_DIV` core clocks.
- R4: A timer counts only while its run bit is 1. When its gate bit is 1, it also needs its gate pin to be high. Otherwise its count bytes hold.
- R5: In counter operation (count-select 1), the count adds one for each 1-to-0 change between two consecutive machine-cycle samples of the timer's count pin. A pin that holds steady adds nothing.
- R6: Mode 0 counts 13 bits, formed by the high byte and low-byte bits [4:0]. Low-byte bits [7:5] are left unchanged. The wrap from all ones to zero sets the timer's flag.
- R7: Mode 1 counts the full 16 bits. The wrap from 0xFFFF to 0x0000 sets the flag.
- R8: Mode 2 counts the low byte only. An increment from 0xFF loads the low byte from the high byte and sets the flag. The high byte does not change.
- R9: In split mode, timer 0's low byte counts 8 bits under timer 0's own run, gate and count-select controls, and sets flag 0 on wrap. Timer 0's high byte counts machine cycles while run1 is 1, and sets flag 1 on wrap.
- R10: A timer placed in split mode itself (timer 1) holds its count bytes.
- R11: A flag clears when its `ack` bit is high for a clock, or when software writes 0 to it. Writing 1 to a flag bit leaves it unchanged. An overflow in the same cycle takes priority and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cnt_pin | input | 2 | External count pins, bit i for timer i |
| gate_pin | input | 2 | Gate pins, bit i for timer i |
| ack | input | 2 | Flag acknowledge, bit i clears flag i |
| ovf_flag | output | 2 | Overflow flags, bit i for timer i |

## Verification
The bench starts and stops each timer through two writes timed to enclose an exact whole number of machine cycles. This makes every expected count exact regardless of the divider phase. A wrong tick rate, or a stop that misses a tick, would show up as an off-by-one count.

The mode 0 wrap checks that low-byte bits [7:5] survive. A 13-bit counter that carried into those bits would read 0x00 instead of 0xE0.

The mode 2 reload and both halves of split mode are checked against their flags. A design that reloaded from the wrong byte, or routed the high-half wrap to flag 0, would be caught.

The gate pin and the count pin are driven both quiet and active. A counter that counted pin levels instead of falling changes would overcount. Writes of 1 to a flag bit are checked to leave the flag alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        TM_13    = 2'd0,
        TM_16    = 2'd1,
        TM_AR8   = 2'd2,
        TM_SPLIT = 2'd3
    } tmr_mode_e;

    localparam int REG_AW = 3;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] A_MODE = 3'd0;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd1;
    localparam logic [REG_AW-1:0] A_LO0  = 3'd2;
    localparam logic [REG_AW-1:0] A_HI0  = 3'd3;
    localparam logic [REG_AW-1:0] A_LO1  = 3'd4;
    localparam logic [REG_AW-1:0] A_HI1  = 3'd5;

endpackage

// File: rtl/tmr_mc_div.sv
module tmr_mc_div #(
    parameter int CYC_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic mc_tick
);
    localparam int CW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign mc_tick = (cnt_q == LAST);

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
    parameter int W     = 2,
    parameter int SYNCS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mc_tick,
    input  logic [W-1:0] cnt_pin,
    input  logic [W-1:0] gate_pin,
    output logic [W-1:0] cnt_fall,
    output logic [W-1:0] gate_lvl
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic [SYNCS-1:0] cs_q, gs_q;
        logic             samp_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cs_q   <= '0;
                gs_q   <= '0;
                samp_q <= 1'b0;
            end else begin
                cs_q <= {cs_q[SYNCS-2:0], cnt_pin[i]};
                gs_q <= {gs_q[SYNCS-2:0], gate_pin[i]};
                if (mc_tick)
                    samp_q <= cs_q[SYNCS-1];
            end
        end

        assign cnt_fall[i] = mc_tick & samp_q & ~cs_q[SYNCS-1];
        assign gate_lvl[i] = gs_q[SYNCS-1];
    end

endmodule

// File: rtl/tmr_count_step.sv
module tmr_count_step
    import tmr_pkg::*;
(
    input  tmr_mode_e   mode,
    input  logic        inc_lo,
    input  logic        inc_hi,
    input  logic [7:0]  lo,
    input  logic [7:0]  hi,
    output logic [7:0]  lo_nx,
    output logic [7:0]  hi_nx,
    output logic        wrap_lo,
    output logic        wrap_hi
);
    logic [12:0] c13;
    logic [15:0] c16;

    assign c13 = {hi, lo[4:0]} + 13'd1;
    assign c16 = {hi, lo} + 16'd1;

    always_comb begin
        lo_nx   = lo;
        hi_nx   = hi;
        wrap_lo = 1'b0;
        wrap_hi = 1'b0;
        unique case (mode)
            TM_13: if (inc_lo) begin
                lo_nx   = {lo[7:5], c13[4:0]};
                hi_nx   = c13[12:5];
                wrap_lo = (hi == 8'hFF) && (lo[4:0] == 5'h1F);
            end
            TM_16: if (inc_lo) begin
                lo_nx   = c16[7:0];
                hi_nx   = c16[15:8];
                wrap_lo = ({hi, lo} == 16'hFFFF);
            end
            TM_AR8: if (inc_lo) begin
                if (lo == 8'hFF) begin
                    lo_nx   = hi;
                    wrap_lo = 1'b1;
                end else begin
                    lo_nx = lo + 8'd1;
                end
            end
            TM_SPLIT: begin
                if (inc_lo) begin
                    lo_nx   = lo + 8'd1;
                    wrap_lo = (lo == 8'hFF);
                end
                if (inc_hi) begin
                    hi_nx   = hi + 8'd1;
                    wrap_hi = (hi == 8'hFF);
                end
            end
        endcase
    end

endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
    import tmr_pkg::*;
#(
    parameter int CYC_DIV = 12,
    parameter int SYNCS   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic [1:0]  cnt_pin,
    input  logic [1:0]  gate_pin,
    input  logic [1:0]  ack,
    output logic [1:0]  ovf_flag
);
    localparam int NT = 2;

    logic          mc_tick;
    logic [NT-1:0] cnt_fall, gate_lvl;

    logic [7:0]    mode_q;
    logic [NT-1:0] run_q;
    logic          flag_q [NT];
    logic [7:0]    lo_q   [NT];
    logic [7:0]    hi_q   [NT];

    logic [7:0]    lo_nx  [NT];
    logic [7:0]    hi_nx  [NT];
    logic [NT-1:0] wrap_lo, wrap_hi, ovf_evt, en_lo, inc_hi, wr_lo, wr_hi;
    tmr_mode_e     mode_t [NT];
    logic          ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    tmr_mc_div #(.CYC_DIV(CYC_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick)
    );

    tmr_pin_edge #(.W(NT), .SYNCS(SYNCS)) u_pin (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick),
        .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .cnt_fall(cnt_fall), .gate_lvl(gate_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
        end else begin
            if (wr_en && (wr_addr == A_MODE)) mode_q <= wr_data;
            if (ctrl_wr)                       run_q  <= wr_data[1:0];
        end
    end

    assign ovf_evt[0] = wrap_lo[0];
    assign ovf_evt[1] = wrap_lo[1] | wrap_hi[0];

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        localparam int MB = 4 * i;
        localparam logic [2:0] LO_A = 3'(2 + 2 * i);
        localparam logic [2:0] HI_A = 3'(3 + 2 * i);

        logic gate_b, ct_b, src_ev, split_halt;

        assign mode_t[i]  = tmr_mode_e'(mode_q[MB+1:MB]);
        assign gate_b     = mode_q[MB+3];
        assign ct_b       = mode_q[MB+2];
        assign src_ev     = ct_b ? cnt_fall[i] : mc_tick;
        assign split_halt = (i == 1) && (mode_t[i] == TM_SPLIT);
        assign en_lo[i]   = run_q[i] && (!gate_b || gate_lvl[i]) && src_ev && !split_halt;
        assign wr_lo[i]   = wr_en && (wr_addr == LO_A);
        assign wr_hi[i]   = wr_en && (wr_addr == HI_A);

        if (i == 0) begin : g_hi_split
            assign inc_hi[i] = (mode_t[i] == TM_SPLIT) && run_q[1] && mc_tick;
        end else begin : g_hi_none
            assign inc_hi[i] = 1'b0;
        end

        tmr_count_step u_step (
            .mode(mode_t[i]), .inc_lo(en_lo[i]), .inc_hi(inc_hi[i]),
            .lo(lo_q[i]), .hi(hi_q[i]),
            .lo_nx(lo_nx[i]), .hi_nx(hi_nx[i]),
            .wrap_lo(wrap_lo[i]), .wrap_hi(wrap_hi[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[i]   <= '0;
                hi_q[i]   <= '0;
                flag_q[i] <= 1'b0;
            end else begin
                lo_q[i] <= wr_lo[i] ? wr_data : lo_nx[i];
                hi_q[i] <= wr_hi[i] ? wr_data : hi_nx[i];
                if (ovf_evt[i])
                    flag_q[i] <= 1'b1;
                else if (ack[i] || (ctrl_wr && !wr_data[2+i]))
                    flag_q[i] <= 1'b0;
            end
        end

        assign ovf_flag[i] = flag_q[i];

        // R11: an overflow event always leaves the flag set
        a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_evt[i] |=> flag_q[i]);

        // R11: an acknowledge with no competing overflow clears the flag
        a_r11_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && !ovf_evt[i]) |=> !flag_q[i]);

        // R4: stopped timer keeps its low byte unless software writes it
        a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[i] && !wr_lo[i]) |=> $stable(lo_q[i]));

        // R7: sixteen-bit increment
        a_r7_wide_incr: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_t[i] == TM_16 && en_lo[i] && !wr_lo[i] && !wr_hi[i])
            |=> ({hi_q[i], lo_q[i]} == $past({hi_q[i], lo_q[i]}) + 16'd1));

        // R8: reload takes the high byte
        a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_t[i] == TM_AR8 && en_lo[i] && lo_q[i] == 8'hFF && !wr_lo[i])
            |=> (lo_q[i] == $past(hi_q[i])));
    end

    // R10: timer 1 in split mode holds both bytes
    a_r10_t1_split_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_t[1] == TM_SPLIT && !wr_lo[1] && !wr_hi[1])
        |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = mode_q;
            A_CTRL:  rd_data = {4'b0, flag_q[1], flag_q[0], run_q};
            A_LO0:   rd_data = lo_q[0];
            A_HI0:   rd_data = hi_q[0];
            A_LO1:   rd_data = lo_q[1];
            A_HI1:   rd_data = hi_q[1];
            default: rd_data = 8'h00;
        endcase
    end

endmodule

// File: tb/sim_dual_tmr_ctr.sv
module sim_dual_tmr_ctr;

    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] ack = 2'b00;
    logic [1:0] ovf_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        string      tag;
        logic [7:0] got;
        logic [7:0] exp;
    } sb_item_t;

    sb_item_t sbq[$];

    always #4 clk = ~clk;

    dual_tmr_ctr #(.CYC_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_pin(cnt_pin), .gate_pin(gate_pin), .ack(ack), .ovf_flag(ovf_flag)
    );

    // monitor: pops scoreboard entries and compares
    always @(posedge clk) begin
        while (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            n_vec++;
            if (it.got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %02h expected %02h", it.tag, it.got, it.exp);
            end
        end
    end

    task automatic chk_reg(string tag, logic [2:0] a, logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        sbq.push_back('{tag, rd_data, exp});
    endtask

    task automatic chk_flags(string tag, logic [1:0] exp);
        @(negedge clk);
        sbq.push_back('{tag, {6'b0, ovf_flag}, {6'b0, exp}});
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // run the selected timers for exactly n machine cycles, flags cleared at start
    task automatic run_ticks(logic [1:0] runb, int n);
        wr(3'd1, {6'b0, runb});
        repeat (DIV * n - 2) @(negedge clk);
        wr(3'd1, 8'h0C);
    endtask

    task automatic finish_run();
        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) chk_reg("R1 reset reg", 3'(a), 8'h00);
        chk_flags("R1 reset flags", 2'b00);

        // R2 register map
        wr(3'd2, 8'hA5); wr(3'd3, 8'h5A); wr(3'd4, 8'h3C); wr(3'd5, 8'hC3);
        wr(3'd0, 8'h21);
        chk_reg("R2 lo0", 3'd2, 8'hA5);
        chk_reg("R2 hi0", 3'd3, 8'h5A);
        chk_reg("R2 lo1", 3'd4, 8'h3C);
        chk_reg("R2 hi1", 3'd5, 8'hC3);
        chk_reg("R2 mode", 3'd0, 8'h21);
        chk_reg("R2 unused addr", 3'd7, 8'h00);

        // R3 / R7 timer rate in mode 1; R4 timer 1 idle
        wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        run_ticks(2'b01, 5);
        chk_reg("R3 lo0 after 5 cycles", 3'd2, 8'h05);
        chk_reg("R3 hi0 after 5 cycles", 3'd3, 8'h00);
        chk_reg("R4 lo1 stopped", 3'd4, 8'h3C);

        // R7 wrap
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        run_ticks(2'b01, 3);
        chk_reg("R7 lo0 wrap", 3'd2, 8'h01);
        chk_reg("R7 hi0 wrap", 3'd3, 8'h00);
        chk_flags("R7 flag0 set", 2'b01);

        // R11 acknowledge clears
        @(negedge clk); ack = 2'b01;
        @(negedge clk); ack = 2'b00;
        chk_flags("R11 ack clear", 2'b00);

        // R6 13-bit mode keeps lo[7:5]
        wr(3'd0, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        run_ticks(2'b01, 2);
        chk_reg("R6 lo0 wrap", 3'd2, 8'hE0);
        chk_reg("R6 hi0 wrap", 3'd3, 8'h00);
        chk_flags("R6 flag0 set", 2'b01);

        // R11 write zero clears, write one leaves alone
        wr(3'd1, 8'h08);
        chk_flags("R11 write zero clears", 2'b00);
        wr(3'd1, 8'h04);
        chk_flags("R11 write one no effect", 2'b00);

        // R8 auto-reload
        wr(3'd0, 8'h02); wr(3'd3, 8'h80); wr(3'd2, 8'hFE);
        run_ticks(2'b01, 3);
        chk_reg("R8 lo0 reloaded", 3'd2, 8'h81);
        chk_reg("R8 hi0 unchanged", 3'd3, 8'h80);
        chk_flags("R8 flag0 set", 2'b01);

        // R9 split mode, timer 1 in mode 1
        wr(3'd0, 8'h13); wr(3'd2, 8'hFF); wr(3'd3, 8'hFE);
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        run_ticks(2'b11, 2);
        chk_reg("R9 lo0 split", 3'd2, 8'h01);
        chk_reg("R9 hi0 split", 3'd3, 8'h00);
        chk_flags("R9 both flags", 2'b11);
        chk_reg("R9 lo1 own count", 3'd4, 8'h02);
        wr(3'd2, 8'h10); wr(3'd3, 8'h20);
        run_ticks(2'b10, 3);
        chk_reg("R9 lo0 needs run0", 3'd2, 8'h10);
        chk_reg("R9 hi0 under run1", 3'd3, 8'h23);

        // R10 timer 1 in split mode holds
        wr(3'd0, 8'h30); wr(3'd4, 8'h05); wr(3'd5, 8'h07);
        run_ticks(2'b10, 4);
        chk_reg("R10 lo1 held", 3'd4, 8'h05);
        chk_reg("R10 hi1 held", 3'd5, 8'h07);

        // R4 gate pin
        wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        gate_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        run_ticks(2'b01, 4);
        chk_reg("R4 gate low blocks", 3'd2, 8'h00);
        gate_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        run_ticks(2'b01, 4);
        chk_reg("R4 gate high counts", 3'd2, 8'h04);

        // R5 counter operation on pin falls
        wr(3'd0, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd1, 8'h02);
        repeat (40) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            cnt_pin[1] = 1'b0;
            repeat (40) @(negedge clk);
            cnt_pin[1] = 1'b1;
            repeat (40) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        wr(3'd1, 8'h0C);
        chk_reg("R5 three falls counted", 3'd4, 8'h03);
        chk_reg("R5 hi1 unchanged", 3'd5, 8'h00);
        for (int k = 0; k < 2; k++) begin
            cnt_pin[1] = 1'b0;
            repeat (40) @(negedge clk);
            cnt_pin[1] = 1'b1;
            repeat (40) @(negedge clk);
        end
        chk_reg("R4 falls ignored when stopped", 3'd4, 8'h03);

        @(posedge clk);
        done = 1;
        finish_run();
    end

endmodule